// File: doc/BRIEF.md
# Radio Data Block Buffer with Host Interrupt

This block sits between a radio data decoder and a host register interface. The decoder hands over finished 16-bit blocks, each tagged with its 2-bit position in the group, through a one-cycle valid strobe. The block keeps the two most recent blocks visible to the host as a "newest" and an "older" register. A third, hidden holding slot catches a block that arrives while two unread blocks are already waiting.

Every accepted block pulls an active-low interrupt down and sets a data-available flag. A host read strobe acknowledges the data. It clears the flag, releases the interrupt and clears the overrun flag. A free-running millisecond tick times how long the host takes to answer. A read that comes after the allowed window sets a sticky late status, and any parked block is then thrown away. A read inside the window moves a parked block into view at once.

Top module: `radblk_buffer`

## Requirements
- R1: A decoder block that arrives when nothing is pending moves the newest register into the older register and loads itself into the newest register. On the following cycle data_avail is 1 and irq_n is 0.
- R2: A host read with no block arriving in the same cycle leaves data_avail at 0, irq_n at 1 and overrun at 0 on the next cycle.
- R3: Each register holds the position tag in bits [17:16] and the data in bits [15:0]. The tag codes are 0 = A, 1 = B, 2 = C and 3 = D.
- R4: A block that arrives while data is pending and overrun is 0 shifts in as in R1 and sets overrun to 1, so both unread blocks stay readable.
- R5: A block that arrives while overrun is 1 goes into the holding slot and leaves both visible registers unchanged. A later such block overwrites the slot.
- R6: A read issued before the window expires, while a block is parked, moves the newest register into the older register and the parked block into the newest register. After it, data_avail and overrun are 0.
- R7: The window count restarts at 0 when data_avail rises and advances on each ms_tick while data is pending. A read once the count has reached LATE_MS sets late_read, which stays 1 until reset. A read before that point leaves late_read unchanged.
- R8: A late read discards a parked block and leaves both visible registers unchanged.
- R9: When a read and a decoder block coincide, the read is handled first. The block is then accepted as if nothing were pending, so data_avail is 1 and overrun is 0 afterwards.
- R10: Synchronous reset clears both registers, the holding slot, every flag and the timer, and drives irq_n to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | One-cycle strobe for a decoded block |
| dec_pos | input | POS_W | Position tag of the decoded block |
| dec_data | input | DATA_W | Data word of the decoded block |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| host_rd | input | 1 | Host register-read strobe |
| last_blk | output | POS_W+DATA_W | Newest block, tag above data |
| prev_blk | output | POS_W+DATA_W | Older block, tag above data |
| irq_n | output | 1 | Active-low interrupt |
| data_avail | output | 1 | Unread data pending |
| overrun | output | 1 | More than one unread block pending |
| late_read | output | 1 | Sticky status for a read after the window |

## Verification
The bench keeps the default 16-bit data and 2-bit tag. It builds the block with LATE_MS set to 4, so the window can expire within a handful of ticks. This makes both sides of the window boundary cheap to reach: a read after three ticks and a read after four. The late-read discard of a parked block becomes reachable in the same short run. It also brings the timer's saturation under extra ticks, and its restart when a block coincides with a read, into a short directed sequence.

// File: rtl/radblk_pkg.sv
package radblk_pkg;

    typedef enum logic [1:0] {
        POS_A = 2'd0,
        POS_B = 2'd1,
        POS_C = 2'd2,
        POS_D = 2'd3
    } blk_pos_e;

    // Per-cycle actions derived from the inputs and the current state
    typedef struct packed {
        logic shift_new;    // new block enters newest register
        logic move_hold;    // parked block enters newest register (read side)
        logic load_hold;    // new block parks in holding slot
        logic drop_hold;    // holding slot emptied
        logic set_avail;
        logic set_ovf;
        logic clr;          // host read acknowledge
        logic start_timer;
        logic late_hit;
    } ctrl_t;

    // Read is applied first, then the arriving block sees the post-read state
    function automatic ctrl_t decide(input logic valid, input logic rd,
                                     input logic avail, input logic ovf,
                                     input logic hold_full, input logic expired);
        ctrl_t c;
        logic  eff_avail;
        logic  eff_ovf;
        c           = '0;
        eff_avail   = avail & ~rd;
        eff_ovf     = ovf & ~rd;
        c.clr       = rd;
        c.late_hit  = rd & expired;
        c.move_hold = rd & ~expired & hold_full;
        c.drop_hold = rd & hold_full;
        if (valid) begin
            c.set_avail   = 1'b1;
            c.start_timer = ~eff_avail;
            c.set_ovf     = eff_avail;
            if (eff_ovf)
                c.load_hold = 1'b1;
            else
                c.shift_new = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/radblk_history.sv
module radblk_history
    import radblk_pkg::*;
#(
    parameter int BLK_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [BLK_W-1:0] new_blk,
    output logic [BLK_W-1:0] last_q,
    output logic [BLK_W-1:0] prev_q,
    output logic             hold_full_q
);
    logic [BLK_W-1:0] hold_q;
    logic [BLK_W-1:0] mid_last;
    logic [BLK_W-1:0] mid_prev;

    // Stage 1: effect of a timely read on the visible pair
    always_comb begin
        mid_last = ctrl.move_hold ? hold_q : last_q;
        mid_prev = ctrl.move_hold ? last_q : prev_q;
    end

    // Stage 2: an arriving block shifts in on top of stage 1
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            prev_q <= '0;
        end else if (ctrl.shift_new) begin
            last_q <= new_blk;
            prev_q <= mid_last;
        end else begin
            last_q <= mid_last;
            prev_q <= mid_prev;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (ctrl.load_hold) begin
            hold_q      <= new_blk;
            hold_full_q <= 1'b1;
        end else if (ctrl.drop_hold) begin
            hold_full_q <= 1'b0;
        end
    end

endmodule

// File: rtl/radblk_flags.sv
module radblk_flags
    import radblk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    output logic  avail_q,
    output logic  ovf_q,
    output logic  irq_n_q,
    output logic  late_q
);
    logic avail_d;
    logic ovf_d;

    always_comb begin
        avail_d = (avail_q & ~ctrl.clr) | ctrl.set_avail;
        ovf_d   = (ovf_q & ~ctrl.clr) | ctrl.set_ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            avail_q <= 1'b0;
            ovf_q   <= 1'b0;
            irq_n_q <= 1'b1;
            late_q  <= 1'b0;
        end else begin
            avail_q <= avail_d;
            ovf_q   <= ovf_d;
            irq_n_q <= ~avail_d;
            late_q  <= late_q | ctrl.late_hit;
        end
    end

endmodule

// File: rtl/radblk_timer.sv
module radblk_timer
    import radblk_pkg::*;
#(
    parameter int LIMIT = 20
) (
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  tick,
    input  logic  pending,
    output logic  expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || ctrl.start_timer || ctrl.clr)
            cnt_q <= '0;
        else if (tick && pending && !expired)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/radblk_buffer.sv
module radblk_buffer
    import radblk_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int POS_W   = 2,
    parameter int LATE_MS = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dec_valid,
    input  logic [POS_W-1:0]        dec_pos,
    input  logic [DATA_W-1:0]       dec_data,
    input  logic                    ms_tick,
    input  logic                    host_rd,
    output logic [POS_W+DATA_W-1:0] last_blk,
    output logic [POS_W+DATA_W-1:0] prev_blk,
    output logic                    irq_n,
    output logic                    data_avail,
    output logic                    overrun,
    output logic                    late_read
);
    localparam int BLK_W = POS_W + DATA_W;

    ctrl_t ctrl;
    logic  hold_full;
    logic  expired;

    assign ctrl = decide(dec_valid, host_rd, data_avail, overrun, hold_full, expired);

    radblk_history #(.BLK_W(BLK_W)) u_hist (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .new_blk     ({dec_pos, dec_data}),
        .last_q      (last_blk),
        .prev_q      (prev_blk),
        .hold_full_q (hold_full)
    );

    radblk_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .avail_q (data_avail),
        .ovf_q   (overrun),
        .irq_n_q (irq_n),
        .late_q  (late_read)
    );

    radblk_timer #(.LIMIT(LATE_MS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .tick    (ms_tick),
        .pending (data_avail),
        .expired (expired)
    );

endmodule

// File: rtl/radblk_buffer_chk.sv
module radblk_buffer_chk #(
    parameter int DATA_W = 16,
    parameter int POS_W  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    dec_valid,
    input logic [POS_W-1:0]        dec_pos,
    input logic [DATA_W-1:0]       dec_data,
    input logic                    host_rd,
    input logic [POS_W+DATA_W-1:0] last_blk,
    input logic [POS_W+DATA_W-1:0] prev_blk,
    input logic                    irq_n,
    input logic                    data_avail,
    input logic                    overrun,
    input logic                    late_read
);
    assert_new_block_R1: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !data_avail && !host_rd |=>
            data_avail && !irq_n && last_blk == $past({dec_pos, dec_data}) &&
            prev_blk == $past(last_blk));

    assert_read_ack_R2: assert property (@(posedge clk) disable iff (rst)
        host_rd && !dec_valid |=> !data_avail && irq_n && !overrun);

    assert_second_unread_R4: assert property (@(posedge clk) disable iff (rst)
        dec_valid && data_avail && !overrun && !host_rd |=>
            overrun && prev_blk == $past(last_blk));

    assert_parked_R5: assert property (@(posedge clk) disable iff (rst)
        dec_valid && overrun && !host_rd |=> $stable(last_blk) && $stable(prev_blk));

    assert_late_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        late_read |=> late_read);

    assert_late_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(late_read) |-> $past(host_rd));

    assert_coincide_R9: assert property (@(posedge clk) disable iff (rst)
        dec_valid && host_rd |=> data_avail && !overrun && !irq_n &&
            last_blk == $past({dec_pos, dec_data}));

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> irq_n && !data_avail && !overrun && !late_read &&
            last_blk == '0 && prev_blk == '0);

endmodule

bind radblk_buffer radblk_buffer_chk #(.DATA_W(DATA_W), .POS_W(POS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dec_valid  (dec_valid),
    .dec_pos    (dec_pos),
    .dec_data   (dec_data),
    .host_rd    (host_rd),
    .last_blk   (last_blk),
    .prev_blk   (prev_blk),
    .irq_n      (irq_n),
    .data_avail (data_avail),
    .overrun    (overrun),
    .late_read  (late_read)
);

// File: tb/radblk_buffer_test.sv
`timescale 1ns/1ps
module radblk_buffer_test;

    localparam int LATE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 1'b0;
    logic [1:0]  dec_pos = 2'd0;
    logic [15:0] dec_data = 16'd0;
    logic        ms_tick = 1'b0;
    logic        host_rd = 1'b0;
    logic [17:0] last_blk;
    logic [17:0] prev_blk;
    logic        irq_n;
    logic        data_avail;
    logic        overrun;
    logic        late_read;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    radblk_buffer #(.DATA_W(16), .POS_W(2), .LATE_MS(LATE)) uut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_pos(dec_pos),
        .dec_data(dec_data), .ms_tick(ms_tick), .host_rd(host_rd),
        .last_blk(last_blk), .prev_blk(prev_blk), .irq_n(irq_n),
        .data_avail(data_avail), .overrun(overrun), .late_read(late_read)
    );

    typedef struct packed {
        logic        v;
        logic        r;
        logic        t;
        logic [1:0]  pos;
        logic [15:0] data;
        logic [17:0] e_last;
        logic [17:0] e_prev;
        logic        e_av;
        logic        e_ov;
        logic        e_late;
        logic [3:0]  req;
    } vec_t;

    // Tags in positions [17:16] per R3
    localparam vec_t VEC [16] = '{
        '{1'b1,1'b0,1'b0,2'd0,16'h1111,18'h01111,18'h00000,1'b1,1'b0,1'b0,4'd1},  // R1
        '{1'b0,1'b0,1'b0,2'd0,16'h0000,18'h01111,18'h00000,1'b1,1'b0,1'b0,4'd1},
        '{1'b0,1'b1,1'b0,2'd0,16'h0000,18'h01111,18'h00000,1'b0,1'b0,1'b0,4'd2},  // R2
        '{1'b1,1'b0,1'b0,2'd1,16'h2222,18'h12222,18'h01111,1'b1,1'b0,1'b0,4'd3},  // R3
        '{1'b1,1'b0,1'b0,2'd2,16'h3333,18'h23333,18'h12222,1'b1,1'b1,1'b0,4'd4},  // R4
        '{1'b1,1'b0,1'b0,2'd3,16'h4444,18'h23333,18'h12222,1'b1,1'b1,1'b0,4'd5},  // R5
        '{1'b0,1'b1,1'b0,2'd0,16'h0000,18'h34444,18'h23333,1'b0,1'b0,1'b0,4'd6},  // R6
        '{1'b1,1'b1,1'b0,2'd0,16'h5555,18'h05555,18'h34444,1'b1,1'b0,1'b0,4'd9},  // R9
        '{1'b1,1'b1,1'b0,2'd1,16'h6666,18'h16666,18'h05555,1'b1,1'b0,1'b0,4'd9},
        '{1'b0,1'b0,1'b1,2'd0,16'h0000,18'h16666,18'h05555,1'b1,1'b0,1'b0,4'd7},  // R7
        '{1'b0,1'b0,1'b1,2'd0,16'h0000,18'h16666,18'h05555,1'b1,1'b0,1'b0,4'd7},
        '{1'b0,1'b0,1'b1,2'd0,16'h0000,18'h16666,18'h05555,1'b1,1'b0,1'b0,4'd7},
        '{1'b0,1'b0,1'b1,2'd0,16'h0000,18'h16666,18'h05555,1'b1,1'b0,1'b0,4'd7},
        '{1'b0,1'b0,1'b1,2'd0,16'h0000,18'h16666,18'h05555,1'b1,1'b0,1'b0,4'd7},
        '{1'b0,1'b1,1'b0,2'd0,16'h0000,18'h16666,18'h05555,1'b0,1'b0,1'b1,4'd7},
        '{1'b1,1'b0,1'b0,2'd2,16'h7777,18'h27777,18'h16666,1'b1,1'b0,1'b1,4'd1}
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [17:0] e_last,
                             input logic [17:0] e_prev, input logic e_av,
                             input logic e_ov, input logic e_late);
        check(tag, "last_blk", 32'(last_blk), 32'(e_last));
        check(tag, "prev_blk", 32'(prev_blk), 32'(e_prev));
        check(tag, "data_avail", 32'(data_avail), 32'(e_av));
        check(tag, "irq_n", 32'(irq_n), 32'(!e_av));
        check(tag, "overrun", 32'(overrun), 32'(e_ov));
        check(tag, "late_read", 32'(late_read), 32'(e_late));
    endtask

    // One clock edge with the given inputs; returns 1 ns after the edge
    task automatic cyc(input logic v, input logic r, input logic t,
                       input logic [1:0] p, input logic [15:0] d);
        dec_valid = v; host_rd = r; ms_tick = t; dec_pos = p; dec_data = d;
        @(posedge clk);
        #1;
        dec_valid = 1'b0; host_rd = 1'b0; ms_tick = 1'b0;
        dec_pos = 2'd0; dec_data = 16'd0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 2'd0, 16'd0);
        cyc(1'b0, 1'b0, 1'b0, 2'd0, 16'd0);
        rst = 1'b0;
    endtask

    task automatic blk(input logic [1:0] p, input logic [15:0] d);
        cyc(1'b1, 1'b0, 1'b0, p, d);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 2'd0, 16'd0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        do_reset();
        check_all("R10", 18'h0, 18'h0, 1'b0, 1'b0, 1'b0);

        // Vector walk
        for (int i = 0; i < 16; i++) begin
            cyc(VEC[i].v, VEC[i].r, VEC[i].t, VEC[i].pos, VEC[i].data);
            check_all($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].e_last,
                      VEC[i].e_prev, VEC[i].e_av, VEC[i].e_ov, VEC[i].e_late);
        end

        // R10 reset mid-run clears sticky late and registers
        do_reset();
        check_all("R10 midrun", 18'h0, 18'h0, 1'b0, 1'b0, 1'b0);

        // R5 holding slot overwritten by a later block; timely read shows latest
        blk(2'd0, 16'h000A);
        blk(2'd1, 16'h000B);
        blk(2'd2, 16'h000C);
        blk(2'd3, 16'h000D);
        check_all("R5 parked", 18'h1000B, 18'h0000A, 1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 2'd0, 16'd0);
        check_all("R5 R6 overwrite", 18'h3000D, 18'h1000B, 1'b0, 1'b0, 1'b0);

        // R8 late read discards the parked block
        do_reset();
        blk(2'd0, 16'h000A);
        blk(2'd1, 16'h000B);
        blk(2'd2, 16'h000C);
        ticks(LATE);
        cyc(1'b0, 1'b1, 1'b0, 2'd0, 16'd0);
        check_all("R8 late read", 18'h1000B, 18'h0000A, 1'b0, 1'b0, 1'b1);
        blk(2'd0, 16'h000E);
        check_all("R8 slot empty", 18'h0000E, 18'h1000B, 1'b1, 1'b0, 1'b1);

        // R9 R6 read moves parked block, coinciding block shifts on top
        do_reset();
        blk(2'd0, 16'h000A);
        blk(2'd1, 16'h000B);
        blk(2'd2, 16'h000C);
        cyc(1'b1, 1'b1, 1'b0, 2'd3, 16'h000D);
        check_all("R9 move+new", 18'h3000D, 18'h2000C, 1'b1, 1'b0, 1'b0);

        // R7 window boundary: one tick short, then exactly at the limit
        do_reset();
        blk(2'd0, 16'h0001);
        ticks(LATE - 1);
        cyc(1'b0, 1'b1, 1'b0, 2'd0, 16'd0);
        check("R7 early", "late_read", 32'(late_read), 32'd0);
        blk(2'd1, 16'h0002);
        ticks(LATE);
        cyc(1'b0, 1'b1, 1'b0, 2'd0, 16'd0);
        check("R7 at limit", "late_read", 32'(late_read), 32'd1);

        // R7 ticks while idle do not advance the window
        do_reset();
        ticks(LATE + 2);
        blk(2'd2, 16'h0003);
        cyc(1'b0, 1'b1, 1'b0, 2'd0, 16'd0);
        check("R7 idle ticks", "late_read", 32'(late_read), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule